// File: doc/BRIEF.md
# Thermal Trip Point Comparator

This block checks two 8-bit temperature readings, one for the die itself (local) and one for an external sensing point (remote), against a trip threshold that belongs to each channel. A channel's threshold is a fixed power-up constant until the host first writes that channel's trip register. From that write on, the written value applies. If either reading reaches its threshold, the block drives an active-low thermal alarm low and drives a fan override output high, which requests full fan speed.

The host writes a trip register through a single-cycle write strobe and a data bus, one pair for each channel. The readings are sampled every clock. The alarm outputs are registered, so they follow the readings one clock later. They are level-based: they clear by themselves once both readings fall back below their thresholds.

Top module: `thermal_trip_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `therm_alarm_n` is 1 and `fan_full` is 0 after that edge.
- R2: Before any write to the local trip register since reset, the local channel violates exactly when `local_temp >= LOCAL_DEFAULT` (default 85).
- R3: Before any write to the remote trip register since reset, the remote channel violates exactly when `remote_temp >= REMOTE_DEFAULT` (default 100).
- R4: Once `local_trip_wr` has been high at a clock edge, the local channel uses the last value written on `local_trip_data` and no longer uses the default, including when the written value is above the default.
- R5: Once `remote_trip_wr` has been high at a clock edge, the remote channel uses the last value written on `remote_trip_data` and no longer uses the default.
- R6: The comparison is unsigned greater-or-equal. A reading equal to the threshold trips. A threshold of 0 always trips. A threshold of 255 trips only at 255.
- R7: `therm_alarm_n` is low after a clock edge exactly when at least one channel violated at that edge. A change in a reading therefore shows one clock later.
- R8: `fan_full` is always the complement of `therm_alarm_n`.
- R9: The alarm is level-based. It deasserts on the first edge at which both readings are below their thresholds, with no clearing action.
- R10: Reset discards the written trip values, and both channels return to their defaults.
- R11: A write to one channel's trip register does not change the other channel's threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_temp | input | 8 | Local temperature reading, unsigned |
| remote_temp | input | 8 | Remote temperature reading, unsigned |
| local_trip_wr | input | 1 | Write strobe for the local trip register |
| local_trip_data | input | 8 | Value written to the local trip register |
| remote_trip_wr | input | 1 | Write strobe for the remote trip register |
| remote_trip_data | input | 8 | Value written to the remote trip register |
| therm_alarm_n | output | 1 | Thermal alarm, low while any channel is at or above its threshold |
| fan_full | output | 1 | Fan override, high while any channel is at or above its threshold |

## Verification
The assertions assume that readings and write strobes are stable around the sampling edge. They also assume that the default-threshold properties only describe the period before each channel's first write, which the checker tracks from the strobes it sees after reset. The stimulus changes every input on the falling clock edge and raises each strobe for one cycle only. It then sweeps all 256 values of one reading while the other is held well below its threshold, so each expected alarm depends on exactly one channel. The sweeps use the defaults first, then several written thresholds, including the extremes 0 and 255.

// File: rtl/thermtrip_pkg.sv
// Package: shared constants for the thermal trip comparator.
// Assumes two channels: index 0 is local, index 1 is remote.
package thermtrip_pkg;
    localparam int TEMP_W    = 8;
    localparam int N_CH      = 2;
    localparam int CH_LOCAL  = 0;
    localparam int CH_REMOTE = 1;
    localparam logic [TEMP_W-1:0] LOCAL_DEF_C  = 8'd85;
    localparam logic [TEMP_W-1:0] REMOTE_DEF_C = 8'd100;
endpackage

// File: rtl/trip_threshold_sel.sv
// trip_threshold_sel: one programmable trip register together with its
// "written" flag. It outputs the written value once a write has happened
// since reset, and the fixed default before that.
// Assumes wr_en is sampled on the rising edge and is synchronous to clk.
module trip_threshold_sel #(
    parameter int          W       = 8,
    parameter logic [W-1:0] DEFAULT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] threshold
);
    logic         written_q;
    logic [W-1:0] prog_q;

    // Set the written flag on the first write; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            written_q <= 1'b0;
        else if (wr_en)
            written_q <= 1'b1;
    end

    // Hold the most recently written value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prog_q <= '0;
        else if (wr_en)
            prog_q <= wr_data;
    end

    // Choose between the written value and the default.
    always_comb begin
        threshold = written_q ? prog_q : DEFAULT;
    end
endmodule

// File: rtl/trip_cmp.sv
// trip_cmp: unsigned greater-or-equal test of a reading against a threshold.
// Purely combinational; assumes both operands share the width W.
module trip_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] reading,
    input  logic [W-1:0] threshold,
    output logic         violate
);
    // Flag a reading at or above the threshold.
    always_comb begin
        violate = (reading >= threshold);
    end
endmodule

// File: rtl/trip_alarm_out.sv
// trip_alarm_out: combines the per-channel violations and registers the
// active-low alarm and the active-high fan override in separate flops.
// Assumes the violation vector settles within one cycle.
module trip_alarm_out #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] violate,
    output logic         alarm_n,
    output logic         fan_full
);
    logic any_violate;

    // Merge the violations of all channels.
    always_comb begin
        any_violate = |violate;
    end

    // Register the active-low alarm; it is idle high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_n <= 1'b1;
        else
            alarm_n <= ~any_violate;
    end

    // Register the fan override; it is idle low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fan_full <= 1'b0;
        else
            fan_full <= any_violate;
    end
endmodule

// File: rtl/thermal_trip_top.sv
// thermal_trip_top: per-channel trip threshold selection and comparison
// for the local and remote readings, merged into registered alarm outputs.
// Assumes readings and write strobes are synchronous to clk.
module thermal_trip_top
    import thermtrip_pkg::*;
#(
    parameter int                 TEMP_W         = thermtrip_pkg::TEMP_W,
    parameter logic [TEMP_W-1:0]  LOCAL_DEFAULT  = LOCAL_DEF_C,
    parameter logic [TEMP_W-1:0]  REMOTE_DEFAULT = REMOTE_DEF_C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] local_temp,
    input  logic [TEMP_W-1:0] remote_temp,
    input  logic              local_trip_wr,
    input  logic [TEMP_W-1:0] local_trip_data,
    input  logic              remote_trip_wr,
    input  logic [TEMP_W-1:0] remote_trip_data,
    output logic              therm_alarm_n,
    output logic              fan_full
);
    localparam int NC = N_CH;

    logic [TEMP_W-1:0] reading_a [NC];
    logic [TEMP_W-1:0] wdata_a   [NC];
    logic [TEMP_W-1:0] thr_a     [NC];
    logic [NC-1:0]     wr_a;
    logic [NC-1:0]     viol;

    // Gather the port signals into per-channel arrays.
    always_comb begin
        reading_a[CH_LOCAL]  = local_temp;
        reading_a[CH_REMOTE] = remote_temp;
        wdata_a[CH_LOCAL]    = local_trip_data;
        wdata_a[CH_REMOTE]   = remote_trip_data;
        wr_a[CH_LOCAL]       = local_trip_wr;
        wr_a[CH_REMOTE]      = remote_trip_wr;
    end

    for (genvar c = 0; c < NC; c++) begin : g_ch
        localparam logic [TEMP_W-1:0] DEF_C =
            (c == CH_LOCAL) ? LOCAL_DEFAULT : REMOTE_DEFAULT;

        trip_threshold_sel #(.W(TEMP_W), .DEFAULT(DEF_C)) u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_a[c]),
            .wr_data   (wdata_a[c]),
            .threshold (thr_a[c])
        );

        trip_cmp #(.W(TEMP_W)) u_cmp (
            .reading   (reading_a[c]),
            .threshold (thr_a[c]),
            .violate   (viol[c])
        );
    end

    trip_alarm_out #(.N(NC)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .violate  (viol),
        .alarm_n  (therm_alarm_n),
        .fan_full (fan_full)
    );
endmodule

// File: rtl/thermal_trip_chk.sv
// thermal_trip_chk: port-level properties of thermal_trip_top. It tracks
// from the strobes whether each channel has been written since reset.
module thermal_trip_chk #(
    parameter int                TEMP_W         = 8,
    parameter logic [TEMP_W-1:0] LOCAL_DEFAULT  = 8'd85,
    parameter logic [TEMP_W-1:0] REMOTE_DEFAULT = 8'd100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] local_temp,
    input  logic [TEMP_W-1:0] remote_temp,
    input  logic              local_trip_wr,
    input  logic              remote_trip_wr,
    input  logic              therm_alarm_n,
    input  logic              fan_full
);
    localparam logic [TEMP_W-1:0] TOP_C = '1;

    logic seen_lw, seen_rw;

    // Remember whether each trip register has been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_lw <= 1'b0;
            seen_rw <= 1'b0;
        end else begin
            seen_lw <= seen_lw | local_trip_wr;
            seen_rw <= seen_rw | remote_trip_wr;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (therm_alarm_n && !fan_full));

    // R8
    fan_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fan_full == !therm_alarm_n));

    // R6
    full_scale_trips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_temp == TOP_C || remote_temp == TOP_C) |=> !therm_alarm_n);

    // R2
    local_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_lw && !local_trip_wr && local_temp >= LOCAL_DEFAULT) |=> !therm_alarm_n);

    // R3
    remote_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_rw && !remote_trip_wr && remote_temp >= REMOTE_DEFAULT) |=> !therm_alarm_n);

    // R9
    both_cool_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_lw && !seen_rw && local_temp < LOCAL_DEFAULT &&
         remote_temp < REMOTE_DEFAULT) |=> therm_alarm_n);
endmodule

bind thermal_trip_top thermal_trip_chk #(
    .TEMP_W         (TEMP_W),
    .LOCAL_DEFAULT  (LOCAL_DEFAULT),
    .REMOTE_DEFAULT (REMOTE_DEFAULT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .local_temp     (local_temp),
    .remote_temp    (remote_temp),
    .local_trip_wr  (local_trip_wr),
    .remote_trip_wr (remote_trip_wr),
    .therm_alarm_n  (therm_alarm_n),
    .fan_full       (fan_full)
);

// File: tb/thermal_trip_top_test.sv
`timescale 1ns/1ps
module thermal_trip_top_test;
    localparam int LDEF = 85;
    localparam int RDEF = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] local_temp = '0, remote_temp = '0;
    logic       local_trip_wr = 1'b0, remote_trip_wr = 1'b0;
    logic [7:0] local_trip_data = '0, remote_trip_data = '0;
    logic       therm_alarm_n, fan_full;

    int checks = 0;
    int failures = 0;
    int lthr = LDEF;
    int rthr = RDEF;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thermal_trip_top uut (
        .clk (clk), .rst_n (rst_n),
        .local_temp (local_temp), .remote_temp (remote_temp),
        .local_trip_wr (local_trip_wr), .local_trip_data (local_trip_data),
        .remote_trip_wr (remote_trip_wr), .remote_trip_data (remote_trip_data),
        .therm_alarm_n (therm_alarm_n), .fan_full (fan_full)
    );

    task automatic check_out(input string tag, input bit exp_alarm);
        checks++;
        if (therm_alarm_n !== !exp_alarm || fan_full !== exp_alarm) begin
            failures++;
            $display("FAIL %s: alarm_n=%b fan=%b expected alarm_n=%b fan=%b",
                     tag, therm_alarm_n, fan_full, !exp_alarm, exp_alarm);
        end
    endtask

    // Drive readings on the falling edge, sample just after the next rise.
    task automatic apply(input int lt, input int rt);
        @(negedge clk);
        local_temp  = lt[7:0];
        remote_temp = rt[7:0];
        @(posedge clk);
        #1;
    endtask

    task automatic write_local(input int v);
        @(negedge clk);
        local_trip_wr = 1'b1; local_trip_data = v[7:0];
        @(negedge clk);
        local_trip_wr = 1'b0;
        lthr = v;
    endtask

    task automatic write_remote(input int v);
        @(negedge clk);
        remote_trip_wr = 1'b1; remote_trip_data = v[7:0];
        @(negedge clk);
        remote_trip_wr = 1'b0;
        rthr = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        local_temp = '0; remote_temp = '0;
        repeat (2) @(posedge clk);
        #1;
        check_out("R1 reset idle", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        lthr = LDEF; rthr = RDEF;
    endtask

    task automatic sweep_local(input string tag);
        for (int t = 0; t < 256; t++) begin
            apply(t, 0);
            check_out(tag, (t >= lthr) || (0 >= rthr));
        end
    endtask

    task automatic sweep_remote(input string tag);
        for (int t = 0; t < 256; t++) begin
            apply(0, t);
            check_out(tag, (0 >= lthr) || (t >= rthr));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 R6 R8: local sweep against its default
        sweep_local("R2 local default sweep");
        // R3 R6 R8: remote sweep against its default
        sweep_remote("R3 remote default sweep");
        // R7: output changes only one edge after the reading
        apply(0, 0);
        @(negedge clk);
        local_temp = 8'd200;
        #1 check_out("R7 no change before edge", 1'b0);
        @(posedge clk); #1;
        check_out("R7 alarm after edge", 1'b1);
        // R9: both channels hot, then one cools, then both cool
        apply(200, 200); check_out("R9 both hot", 1'b1);
        apply(10, 200);  check_out("R9 remote still hot", 1'b1);
        apply(10, 10);   check_out("R9 level clears", 1'b0);
        // R4: local written above its default
        write_local(150);
        sweep_local("R4 local programmed 150");
        // R11: remote still on its default
        sweep_remote("R11 remote unaffected by local write");
        // R5: remote written below its default
        write_remote(20);
        sweep_remote("R5 remote programmed 20");
        sweep_local("R11 local unaffected by remote write");
        // R6: extremes of the threshold
        write_local(0);
        apply(0, 0); check_out("R6 threshold 0 always trips", 1'b1);
        write_remote(255);
        write_local(255);
        sweep_local("R6 threshold 255 local");
        sweep_remote("R6 threshold 255 remote");
        // R10: reset restores the defaults
        do_reset();
        apply(90, 0);  check_out("R10 local default after reset", 1'b1);
        apply(84, 99); check_out("R10 below both defaults", 1'b0);
        apply(0, 100); check_out("R10 remote default after reset", 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule